// File: doc/BRIEF.md
# Oversampled Serial Receiver

This block turns an idle-high asynchronous serial line into bytes. A separate rate generator provides a strobe at sixteen times the bit rate, and all line sampling happens on that strobe. The raw line first passes through a two-stage synchronizer that resets to the idle level. A falling edge seen on a tick opens a candidate frame. Eight ticks later, at mid-bit, the receiver checks that the line is still low and only then accepts the start bit. Every later bit is taken at its centre, sixteen ticks apart: eight data bits arrive least significant first, then an optional parity bit, then the stop bit.

At the stop sample the receiver gives its verdict as single-cycle pulses. It raises a byte strobe with the assembled byte, a frame-error pulse, or a parity-error pulse. A byte is delivered only when the stop bit is high and, with parity enabled, the parity bit agrees with the selected polarity. A line held low keeps producing one frame error per character time. A control input enables reception; dropping it sends the receiver to idle and silences every output pulse.

Top module: `uart_os_receiver`

## Requirements
- R1: After a synchronous reset, byte_valid, frame_err and parity_err are low and byte_data is 0.
- R2: A frame is a 0 start bit, eight data bits with the least significant bit first, an optional parity bit and a stop bit. A frame with a high stop bit (and correct parity when enabled) gives one byte_valid pulse one clock wide with the byte on byte_data. byte_data holds its value until the next delivered byte.
- R3: A low level seen on a tick is accepted as a start only if the line is still low 8 ticks later. Otherwise it is dropped as a glitch and no pulse results.
- R4: Once a start is accepted, each further bit is sampled every 16 ticks. Data bits fall 16 to 128 ticks after the start centre, and the stop bit falls at 144 ticks (160 with parity).
- R5: When parity_en is 1, a parity bit follows the data. parity_odd=0 selects even parity: data plus parity bit hold an even number of ones. parity_odd=1 selects odd parity: they hold an odd number of ones.
- R6: When parity_en is 1 and the parity bit does not match, parity_err pulses for one clock at the stop sample and no byte is delivered.
- R7: A low stop bit raises a one-clock frame_err pulse and no byte is delivered.
- R8: If the line is still low after a failed stop bit, the receiver keeps framing. A line held low gives one frame_err every character time: 160 ticks without parity and 176 ticks with parity.
- R9: While rx_enable is 0 the receiver is idle and no pulse appears. A frame cut short by dropping rx_enable is discarded.
- R10: A start needs a high-to-low transition. A line that is already low when reception is enabled does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Reception enable |
| os_tick | input | 1 | One-clock strobe at 16x the bit rate |
| parity_en | input | 1 | A parity bit follows the data |
| parity_odd | input | 1 | 1 selects odd parity, 0 even |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| byte_valid | output | 1 | One-clock pulse: byte_data holds a good byte |
| byte_data | output | 8 | Last byte received |
| frame_err | output | 1 | One-clock pulse on a low stop bit |
| parity_err | output | 1 | One-clock pulse on a parity mismatch |

## Verification
On every cycle the assertions check the following:
- the verdict pulses last exactly one clock;
- a delivered byte never coincides with a frame or parity error;
- byte_data changes only together with the byte strobe;
- parity errors occur only when parity is enabled;
- nothing is reported in the clock after rx_enable is low.

The bench scenarios cover what depends on frame content and timing: bit order, both parity polarities, rejection of short glitches, the character-time spacing of frame errors on a held-low line, and the need for a real falling edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_REARM
    } rx_state_e;

    typedef enum logic [1:0] {
        SLOT_DATA,
        SLOT_PARITY,
        SLOT_STOP
    } slot_kind_e;

    // One centre sample handed from the sequencer to the assembler
    typedef struct packed {
        logic       valid;
        slot_kind_e kind;
        logic       level;
    } bit_slot_t;

    typedef struct packed {
        logic good;
        logic frame_bad;
        logic parity_bad;
    } frame_verdict_t;

    // Even parity when odd_sel=0: data ones plus the parity bit must be even
    function automatic logic parity_matches(input logic data_xor,
                                            input logic par_bit,
                                            input logic odd_sel);
        return (data_xor ^ par_bit) == odd_sel;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_bit_sequencer.sv
module rx_bit_sequencer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      tick,
    input  logic      line,
    input  logic      parity_en,
    output bit_slot_t slot
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_BITS - 1);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic             prev_q;
    bit_slot_t        slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            prev_q  <= 1'b1;
            slot_q  <= '0;
        end else begin
            slot_q.valid <= 1'b0;
            // the previous-level register follows the line even while disabled,
            // so a line already low never looks like a new edge
            if (tick) begin
                prev_q <= line;
            end
            if (!enable) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else if (tick) begin
                unique case (state_q)
                    ST_IDLE: begin
                        cnt_q <= '0;
                        if (prev_q && !line) begin
                            state_q <= ST_START;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == HALF_LAST) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            state_q <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == FULL_LAST) begin
                            cnt_q        <= '0;
                            slot_q.valid <= 1'b1;
                            slot_q.kind  <= SLOT_DATA;
                            slot_q.level <= line;
                            if (idx_q == LAST_IDX) begin
                                state_q <= parity_en ? ST_PARITY : ST_STOP;
                            end else begin
                                idx_q <= idx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        if (cnt_q == FULL_LAST) begin
                            cnt_q        <= '0;
                            slot_q.valid <= 1'b1;
                            slot_q.kind  <= SLOT_PARITY;
                            slot_q.level <= line;
                            state_q      <= ST_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == FULL_LAST) begin
                            cnt_q        <= '0;
                            slot_q.valid <= 1'b1;
                            slot_q.kind  <= SLOT_STOP;
                            slot_q.level <= line;
                            state_q      <= line ? ST_IDLE : ST_REARM;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_REARM: begin
                        // a line still low one bit after a failed stop is framed
                        // as the centre of the next start bit
                        if (line) begin
                            state_q <= ST_IDLE;
                            cnt_q   <= '0;
                        end else if (cnt_q == FULL_LAST) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            state_q <= ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    assign slot = slot_q;
endmodule

// File: rtl/rx_char_assembler.sv
module rx_char_assembler
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  bit_slot_t            slot,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 frame_err,
    output logic                 parity_err
);
    logic [DATA_BITS-1:0] shift_q;
    logic                 par_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 valid_q, fe_q, pe_q;
    frame_verdict_t       verdict;
    logic                 stop_slot;

    assign stop_slot = slot.valid && (slot.kind == SLOT_STOP) && enable;

    always_comb begin
        verdict.frame_bad  = !slot.level;
        verdict.parity_bad = parity_en && !parity_matches(^shift_q, par_q, parity_odd);
        verdict.good       = !verdict.frame_bad && !verdict.parity_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            par_q   <= 1'b0;
            data_q  <= '0;
            valid_q <= 1'b0;
            fe_q    <= 1'b0;
            pe_q    <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            fe_q    <= 1'b0;
            pe_q    <= 1'b0;
            if (slot.valid && slot.kind == SLOT_DATA) begin
                shift_q <= {slot.level, shift_q[DATA_BITS-1:1]};
            end
            if (slot.valid && slot.kind == SLOT_PARITY) begin
                par_q <= slot.level;
            end
            if (stop_slot) begin
                valid_q <= verdict.good;
                fe_q    <= verdict.frame_bad;
                pe_q    <= verdict.parity_bad;
                if (verdict.good) begin
                    data_q <= shift_q;
                end
            end
        end
    end

    assign byte_valid = valid_q;
    assign byte_data  = data_q;
    assign frame_err  = fe_q;
    assign parity_err = pe_q;
endmodule

// File: rtl/uart_os_receiver.sv
module uart_os_receiver
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_enable,
    input  logic                 os_tick,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 rx_serial,
    output logic                 byte_valid,
    output logic [DATA_BITS-1:0] byte_data,
    output logic                 frame_err,
    output logic                 parity_err
);
    logic      line_s;
    bit_slot_t slot;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_serial),
        .dout (line_s)
    );

    rx_bit_sequencer #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (rx_enable),
        .tick      (os_tick),
        .line      (line_s),
        .parity_en (parity_en),
        .slot      (slot)
    );

    rx_char_assembler #(.DATA_BITS(DATA_BITS)) i_asm (
        .clk        (clk),
        .rst        (rst),
        .enable     (rx_enable),
        .slot       (slot),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_err  (frame_err),
        .parity_err (parity_err)
    );
endmodule

// File: rtl/uart_os_receiver_chk.sv
module uart_os_receiver_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 rx_enable,
    input logic                 parity_en,
    input logic                 byte_valid,
    input logic [DATA_BITS-1:0] byte_data,
    input logic                 frame_err,
    input logic                 parity_err
);
    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |-> $stable(byte_data));

    // R7
    frame_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    // R7
    frame_drops_byte_chk: assert property (@(posedge clk) disable iff (rst)
        frame_err |-> !byte_valid);

    // R6
    parity_drops_byte_chk: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> !byte_valid);

    // R5
    parity_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        parity_err |-> $past(parity_en));

    // R9
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !byte_valid && !frame_err && !parity_err);
endmodule

bind uart_os_receiver uart_os_receiver_chk #(.DATA_BITS(DATA_BITS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_enable  (rx_enable),
    .parity_en  (parity_en),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .frame_err  (frame_err),
    .parity_err (parity_err)
);

// File: tb/test_uart_os_receiver.sv
module test_uart_os_receiver;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = TICK_DIV * 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_enable = 1'b0;
    logic       os_tick = 1'b0;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       rx_serial = 1'b1;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       frame_err;
    logic       parity_err;

    int n_checks = 0;
    int n_bad = 0;
    int n_valid = 0;
    int n_fe = 0;
    int n_pe = 0;
    int cyc = 0;
    int fe_t = 0;
    int fe_prev_t = 0;
    logic [7:0] last_data = 8'h00;
    int tick_cnt = 0;

    always #2 clk = ~clk;

    uart_os_receiver i_uart_os_receiver (
        .clk        (clk),
        .rst        (rst),
        .rx_enable  (rx_enable),
        .os_tick    (os_tick),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .rx_serial  (rx_serial),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .frame_err  (frame_err),
        .parity_err (parity_err)
    );

    always @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        os_tick  <= (tick_cnt == TICK_DIV - 1);
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (byte_valid) begin
                n_valid = n_valid + 1;
                last_data = byte_data;
            end
            if (frame_err) begin
                n_fe = n_fe + 1;
                fe_prev_t = fe_t;
                fe_t = cyc;
            end
            if (parity_err) n_pe = n_pe + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_bits(input int nbits);
        repeat (nbits * BIT_CLKS) @(posedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                              input logic pflip, input logic stop);
        parity_en  <= pen;
        parity_odd <= podd;
        @(posedge clk);
        rx_serial <= 1'b0;
        hold_bits(1);
        for (int b = 0; b < 8; b++) begin
            rx_serial <= d[b];
            hold_bits(1);
        end
        if (pen) begin
            rx_serial <= (^d) ^ podd ^ pflip;
            hold_bits(1);
        end
        rx_serial <= stop;
        hold_bits(1);
        rx_serial <= 1'b1;
        hold_bits(3);
    endtask

    // {pen, podd, pflip, stop, data[7:0], exp_valid, exp_fe, exp_pe}
    localparam int NVEC = 9;
    localparam logic [14:0] VECS [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h55, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hA3, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h37, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 1'b1, 8'hC8, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b1},
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 1'b0, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b1, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0}
    };

    initial begin
        int v0, f0, p0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs after reset", {byte_valid, frame_err, parity_err, byte_data}, 0);
        @(posedge clk);
        rst <= 1'b0;
        rx_enable <= 1'b1;
        hold_bits(2);

        // vector table: R2 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            v0 = n_valid; f0 = n_fe; p0 = n_pe;
            send_frame(VECS[i][10:3], VECS[i][14], VECS[i][13], VECS[i][12], VECS[i][11]);
            chk($sformatf("R2 R4 vec%0d byte count", i), n_valid - v0, int'(VECS[i][2]));
            if (VECS[i][2]) chk($sformatf("R2 R5 vec%0d data", i), last_data, VECS[i][10:3]);
            chk($sformatf("R7 vec%0d frame errors", i), n_fe - f0, int'(VECS[i][1]));
            chk($sformatf("R6 vec%0d parity errors", i), n_pe - p0, int'(VECS[i][0]));
        end

        // R3 glitch shorter than half a bit
        parity_en <= 1'b0;
        v0 = n_valid; f0 = n_fe;
        @(posedge clk);
        rx_serial <= 1'b0;
        repeat (24) @(posedge clk);
        rx_serial <= 1'b1;
        hold_bits(3);
        chk("R3 glitch gives no byte", n_valid - v0, 0);
        chk("R3 glitch gives no frame error", n_fe - f0, 0);
        send_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R3 byte after glitch", last_data, 8'h96);

        // R8 held low without parity
        v0 = n_valid; f0 = n_fe;
        @(posedge clk);
        rx_serial <= 1'b0;
        hold_bits(20);
        rx_serial <= 1'b1;
        hold_bits(3);
        chk("R8 held low frame errors", n_fe - f0, 2);
        chk("R8 spacing 160 ticks", fe_t - fe_prev_t, 160 * TICK_DIV);
        chk("R8 held low no byte", n_valid - v0, 0);

        // R8 held low with even parity
        parity_en <= 1'b1;
        parity_odd <= 1'b0;
        v0 = n_valid; f0 = n_fe; p0 = n_pe;
        @(posedge clk);
        rx_serial <= 1'b0;
        hold_bits(22);
        rx_serial <= 1'b1;
        hold_bits(3);
        chk("R8 parity held low frame errors", n_fe - f0, 2);
        chk("R8 parity spacing 176 ticks", fe_t - fe_prev_t, 176 * TICK_DIV);
        chk("R5 zero data even parity ok", n_pe - p0, 0);
        parity_en <= 1'b0;

        // R9 frame while disabled
        rx_enable <= 1'b0;
        v0 = n_valid; f0 = n_fe;
        send_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R9 disabled no byte", n_valid - v0, 0);
        // R9 enable dropped mid-frame
        rx_enable <= 1'b1;
        hold_bits(1);
        @(posedge clk);
        rx_serial <= 1'b0;
        hold_bits(1);
        rx_serial <= 1'b1;
        repeat (100) @(posedge clk);
        rx_enable <= 1'b0;
        repeat (8) @(posedge clk);
        rx_enable <= 1'b1;
        hold_bits(12);
        chk("R9 aborted frame no byte", n_valid - v0, 0);
        chk("R9 aborted frame no frame error", n_fe - f0, 0);

        // R10 line already low at enable
        rx_enable <= 1'b0;
        rx_serial <= 1'b0;
        hold_bits(2);
        rx_enable <= 1'b1;
        hold_bits(12);
        rx_serial <= 1'b1;
        hold_bits(3);
        chk("R10 no start without edge", n_fe - f0, 0);
        chk("R10 no byte without edge", n_valid - v0, 0);
        send_frame(8'h42, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R10 receiver alive afterwards", last_data, 8'h42);

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks = n_checks + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule